// File: doc/BRIEF.md
# Motion Coprocessor Host Register Interface

This block is the host-facing register front end of a motion-control coprocessor. A host processor reaches it through a 4-bit offset bus, a 12-bit data bus, a select and separate read and write strobes. Reads and writes use the same sixteen offsets but decode to different registers. Writes land in two register files that the rotation-transform and PWM engines consume. Writes to a control word set the converter channel enables, the clock halving option, the transform direction and the two interrupt enables. Reads return rotation results, converter results, the control word, or a status word.

The transform engine and the converter report completion with single-cycle done pulses. Each pulse latches a source flag. The single interrupt line is high while any latched flag has its enable set. Reading the status word returns the flags and a summary bit, and that read clears the flags. Writing either angle register issues a one-cycle start pulse to the transform engine. A synchronous chip reset returns every register and flag to zero.

Top module: `coproc_host_if`

## Requirements
- R1: While `rst` is high at a clock edge, every write register, the control word and both source flags are cleared. After reset `irq`, `rot_start` and all control outputs are 0.
- R2: A write (`sel` and `wr` high at a clock edge) to offsets 0x0–0x4 stores `wdata` in rotation-input slot `addr`, shown on `rot_in[addr*12 +: 12]`. A write to offsets 0x5–0xA stores `wdata` in PWM slot `addr-5`, shown on `pwm_cfg`.
- R3: A write to offset 0xD loads the control word. Only bits 3 (`adc_u_en`), 4 (`adc_aux_en`), 5 (`clk_div2`), 6 (rotation interrupt enable), 7 (converter interrupt enable) and 10 (`rot_fwd`) are kept; the rest read as 0. A read at 0xD returns the stored word.
- R4: With `sel` and `rd` high, `rdata` is rotation result slot `addr` for offsets 0x0–0x3 and converter result slot `addr-5` for offsets 0x5–0x8. It is 0 for offsets 0x4, 0x9–0xC and 0xF.
- R5: Writes to offsets 0xB, 0xC, 0xE and 0xF change no register, no output and no readable value.
- R6: An `adc_done` pulse sets status bit 0 and a `rot_done` pulse sets status bit 1. A read of offset 0xE returns the flags as they stood before that edge and clears them at that edge. A done pulse in the same cycle as that read leaves its flag set.
- R7: `irq` is high exactly when (status bit 0 and control bit 7) or (status bit 1 and control bit 6). Status bit 11 reads the same value as `irq`. A flag whose enable is clear is still visible in the status word.
- R8: A write to offset 0x0 or offset 0x4 drives `rot_start` high for exactly the next clock cycle. No other access does.
- R9: `rdata` is 0 whenever `sel` or `rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous chip reset, active high |
| sel | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 4 | Register offset |
| wdata | input | 12 | Write data |
| rdata | output | 12 | Read data, combinational |
| rot_res | input | 48 | Four rotation results from the transform engine |
| adc_res | input | 48 | Four converter results |
| adc_done | input | 1 | Converter completion pulse |
| rot_done | input | 1 | Transform completion pulse |
| rot_in | output | 60 | Five rotation input registers |
| pwm_cfg | output | 72 | Period, three on-times, dead time, pulse deletion |
| rot_start | output | 1 | Transform start pulse |
| rot_fwd | output | 1 | Forward-transform mode select |
| adc_u_en | output | 1 | Converter channel U enable |
| adc_aux_en | output | 1 | Converter auxiliary channel enable |
| clk_div2 | output | 1 | Clock divide-by-two enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
Random mixes of reads and writes over all sixteen offsets, with randomly timed done pulses, separate the decode of the read space from the decode of the write space. They also separate flag setting from flag clearing. Directed cases cover the following:
- An all-ones control write, which exposes the mask.
- A source that completes with its enable clear, which separates the latched flag from the interrupt.
- A done pulse that lands in the same cycle as a status read, which exposes a clear that wrongly takes priority.
- Writes to every unmapped offset, which expose stray decode aliasing.

// File: rtl/coproc_host_if.sv
module coproc_host_if #(
  parameter int AW = 4,
  parameter int DW = 12,
  parameter int ROT_IN_N = 5,
  parameter int ROT_OUT_N = 4,
  parameter int ADC_N = 4,
  parameter int PWM_N = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic [ROT_OUT_N*DW-1:0] rot_res,
  input  logic [ADC_N*DW-1:0]     adc_res,
  input  logic                    adc_done,
  input  logic                    rot_done,
  output logic [ROT_IN_N*DW-1:0]  rot_in,
  output logic [PWM_N*DW-1:0]     pwm_cfg,
  output logic                    rot_start,
  output logic                    rot_fwd,
  output logic                    adc_u_en,
  output logic                    adc_aux_en,
  output logic                    clk_div2,
  output logic                    irq
);

  localparam int PWM_BASE  = ROT_IN_N;
  localparam int ADC_BASE  = 5;
  localparam int ANG_A_OFS = 0;
  localparam int ANG_B_OFS = ROT_IN_N - 1;
  localparam int CTRL_OFS  = 13;
  localparam int STAT_OFS  = 14;
  localparam int B_UEN = 3, B_AUX = 4, B_DIV = 5, B_RIE = 6, B_AIE = 7, B_FWD = 10;
  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << B_UEN) | (1 << B_AUX) | (1 << B_DIV) |
                                            (1 << B_RIE) | (1 << B_AIE) | (1 << B_FWD));

  logic [DW-1:0] ctrl_q;
  logic          adc_flag, rot_flag, start_q;
  logic [DW-1:0] stat_word;

  wire wr_hit  = sel & wr;
  wire rd_hit  = sel & rd;
  wire stat_rd = rd_hit && (addr == AW'(STAT_OFS));

  for (genvar i = 0; i < ROT_IN_N; i++) begin : g_rot
    logic [DW-1:0] q;
    always_ff @(posedge clk)
      if (rst) q <= '0;
      else if (wr_hit && addr == AW'(i)) q <= wdata;
    assign rot_in[i*DW +: DW] = q;
  end

  for (genvar i = 0; i < PWM_N; i++) begin : g_pwm
    logic [DW-1:0] q;
    always_ff @(posedge clk)
      if (rst) q <= '0;
      else if (wr_hit && addr == AW'(PWM_BASE + i)) q <= wdata;
    assign pwm_cfg[i*DW +: DW] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      adc_flag <= 1'b0;
      rot_flag <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      if (wr_hit && addr == AW'(CTRL_OFS)) ctrl_q <= wdata & CTRL_MASK;
      adc_flag <= (adc_flag & ~stat_rd) | adc_done;
      rot_flag <= (rot_flag & ~stat_rd) | rot_done;
      start_q  <= wr_hit && (addr == AW'(ANG_A_OFS) || addr == AW'(ANG_B_OFS));
    end
  end

  assign irq        = (adc_flag & ctrl_q[B_AIE]) | (rot_flag & ctrl_q[B_RIE]);
  assign rot_start  = start_q;
  assign rot_fwd    = ctrl_q[B_FWD];
  assign adc_u_en   = ctrl_q[B_UEN];
  assign adc_aux_en = ctrl_q[B_AUX];
  assign clk_div2   = ctrl_q[B_DIV];

  always_comb begin
    stat_word         = '0;
    stat_word[DW-1]   = irq;
    stat_word[1]      = rot_flag;
    stat_word[0]      = adc_flag;
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      if (int'(addr) < ROT_OUT_N)
        rdata = rot_res[int'(addr)*DW +: DW];
      else if (int'(addr) >= ADC_BASE && int'(addr) < ADC_BASE + ADC_N)
        rdata = adc_res[(int'(addr) - ADC_BASE)*DW +: DW];
      else if (addr == AW'(CTRL_OFS))
        rdata = ctrl_q;
      else if (addr == AW'(STAT_OFS))
        rdata = stat_word;
    end
  end

endmodule

// File: rtl/coproc_host_if_chk.sv
module coproc_host_if_chk #(
  parameter int AW = 4,
  parameter int DW = 12,
  parameter int ROT_IN_N = 5,
  parameter int PWM_N = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   sel,
  input logic                   rd,
  input logic                   wr,
  input logic [AW-1:0]          addr,
  input logic [DW-1:0]          rdata,
  input logic                   adc_done,
  input logic                   rot_done,
  input logic [DW-1:0]          ctrl_q,
  input logic [ROT_IN_N*DW-1:0] rot_in,
  input logic [PWM_N*DW-1:0]    pwm_cfg,
  input logic                   rot_start,
  input logic                   irq
);

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd) |-> rdata == '0);                                              // R9

  AST_START_AFTER_ANGLE: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && (addr == AW'(0) || addr == AW'(ROT_IN_N-1))) |=> rot_start);  // R8

  AST_START_ONLY_ANGLE: assert property (@(posedge clk) disable iff (rst)
    !(sel && wr && (addr == AW'(0) || addr == AW'(ROT_IN_N-1))) |=> !rot_start); // R8

  AST_ADC_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (adc_done && ctrl_q[7] && !(sel && wr && addr == AW'(13))) |=> irq);        // R7

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[7:6] == 2'b00) |-> !irq);                                           // R7

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sel && rd && addr == AW'(14) && !adc_done && !rot_done) |=> !irq);         // R6

  AST_UNMAPPED_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && addr >= AW'(11) && addr != AW'(13))
      |=> ($stable(rot_in) && $stable(pwm_cfg) && $stable(ctrl_q)));           // R5

endmodule

bind coproc_host_if coproc_host_if_chk #(.AW(AW), .DW(DW), .ROT_IN_N(ROT_IN_N), .PWM_N(PWM_N)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .rd(rd), .wr(wr), .addr(addr), .rdata(rdata),
  .adc_done(adc_done), .rot_done(rot_done), .ctrl_q(ctrl_q), .rot_in(rot_in),
  .pwm_cfg(pwm_cfg), .rot_start(rot_start), .irq(irq)
);

// File: tb/tb_coproc_host_if.sv
module tb_coproc_host_if;
  logic clk = 0, rst = 1, sel = 0, rd = 0, wr = 0, adc_done = 0, rot_done = 0;
  logic [3:0]  addr = 0;
  logic [11:0] wdata = 0, rdata;
  logic [47:0] rot_res = 0, adc_res = 0;
  logic [59:0] rot_in;
  logic [71:0] pwm_cfg;
  logic rot_start, rot_fwd, adc_u_en, adc_aux_en, clk_div2, irq;

  coproc_host_if dut (
    .clk(clk), .rst(rst), .sel(sel), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rot_res(rot_res), .adc_res(adc_res), .adc_done(adc_done),
    .rot_done(rot_done), .rot_in(rot_in), .pwm_cfg(pwm_cfg), .rot_start(rot_start),
    .rot_fwd(rot_fwd), .adc_u_en(adc_u_en), .adc_aux_en(adc_aux_en),
    .clk_div2(clk_div2), .irq(irq)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [11:0] m_rot [5];
  logic [11:0] m_pwm [6];
  logic [11:0] m_ctrl;
  bit m_af, m_rf;

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_irq();
    return (m_af & m_ctrl[7]) | (m_rf & m_ctrl[6]);
  endfunction

  function automatic logic [11:0] exp_rd(input bit r, input logic [3:0] a);
    if (!r) return 12'h000;
    if (a <= 4'd3) return rot_res[a*12 +: 12];
    if (a >= 4'd5 && a <= 4'd8) return adc_res[(a-5)*12 +: 12];
    if (a == 4'hD) return m_ctrl;
    if (a == 4'hE) return {m_irq(), 9'b0, m_rf, m_af};
    return 12'h000;
  endfunction

  function automatic logic [59:0] pk_rot();
    logic [59:0] v;
    for (int i = 0; i < 5; i++) v[i*12 +: 12] = m_rot[i];
    return v;
  endfunction

  function automatic logic [71:0] pk_pwm();
    logic [71:0] v;
    for (int i = 0; i < 6; i++) v[i*12 +: 12] = m_pwm[i];
    return v;
  endfunction

  function automatic string rd_tag(input bit r, input logic [3:0] a);
    if (!r) return "R9";
    if (a == 4'hE) return "R6";
    if (a == 4'hD) return "R3";
    return "R4";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_rot[i] = 0;
    for (int i = 0; i < 6; i++) m_pwm[i] = 0;
    m_ctrl = 0; m_af = 0; m_rf = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; sel = 0; rd = 0; wr = 0; adc_done = 0; rot_done = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    chk({irq, rot_start, rot_fwd, adc_u_en, adc_aux_en, clk_div2} == 6'b0, "R1 outputs", {irq, rot_start, rot_fwd, adc_u_en, adc_aux_en, clk_div2}, 0);
    chk(rot_in == 0 && pwm_cfg == 0, "R1 registers", {rot_in[11:0], pwm_cfg[59:0]}, 0);
  endtask

  task automatic op(input bit w, input bit r, input logic [3:0] a, input logic [11:0] d,
                    input bit ad, input bit rdn);
    logic [11:0] e;
    bit exp_start, unm;
    @(negedge clk);
    sel = w | r; wr = w; rd = r; addr = a; wdata = d; adc_done = ad; rot_done = rdn;
    rot_res = {16'($urandom()), 32'($urandom())};
    adc_res = {16'($urandom()), 32'($urandom())};
    #1;
    e = exp_rd(r, a);
    chk(rdata == e, rd_tag(r, a), rdata, e);
    @(posedge clk);
    exp_start = w && (a == 4'd0 || a == 4'd4);
    unm = w && (a == 4'hB || a == 4'hC || a == 4'hE || a == 4'hF);
    if (w) begin
      if (a <= 4'd4) m_rot[a] = d;
      else if (a <= 4'hA) m_pwm[a-5] = d;
      else if (a == 4'hD) m_ctrl = d & 12'h4F8;
    end
    m_af = (m_af & !(r && a == 4'hE)) | ad;
    m_rf = (m_rf & !(r && a == 4'hE)) | rdn;
    #1;
    chk(rot_start == exp_start, "R8 start", rot_start, exp_start);
    chk(irq == m_irq(), "R7 irq", irq, m_irq());
    chk(rot_in == pk_rot() && pwm_cfg == pk_pwm(), unm ? "R5 regs" : "R2 regs", {rot_in[11:0], pwm_cfg[59:0]}, {pk_rot()[11:0], pk_pwm()[59:0]});
    chk({rot_fwd, clk_div2, adc_aux_en, adc_u_en} == {m_ctrl[10], m_ctrl[5], m_ctrl[4], m_ctrl[3]}, "R3 ctrl outs",
        {rot_fwd, clk_div2, adc_aux_en, adc_u_en}, {m_ctrl[10], m_ctrl[5], m_ctrl[4], m_ctrl[3]});
  endtask

  task automatic idle();
    op(0, 0, 4'($urandom()), 12'($urandom()), 0, 0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    op(0, 1, 4'hE, 0, 0, 0);
    op(0, 1, 4'hD, 0, 0, 0);
    // R3 mask check with all ones
    op(1, 0, 4'hD, 12'hFFF, 0, 0);
    op(0, 1, 4'hD, 0, 0, 0);
    // R7 disabled source stays quiet but flagged
    op(1, 0, 4'hD, 12'h000, 0, 0);
    op(0, 0, 0, 0, 1, 0);
    op(0, 1, 4'hE, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1);
    op(1, 0, 4'hD, 12'h040, 0, 0);
    op(0, 1, 4'hE, 0, 0, 0);
    // R6 done during status read keeps flag
    op(1, 0, 4'hD, 12'h0C0, 0, 0);
    op(0, 0, 0, 0, 1, 0);
    op(0, 1, 4'hE, 0, 1, 0);
    op(0, 1, 4'hE, 0, 0, 0);
    // R2 fill all write registers, R8 angle writes
    for (int i = 0; i <= 10; i++) op(1, 0, 4'(i), 12'($urandom()), 0, 0);
    // R5 unmapped writes
    op(1, 0, 4'hB, 12'hABC, 0, 0);
    op(1, 0, 4'hC, 12'h123, 0, 0);
    op(1, 0, 4'hE, 12'hFFF, 0, 0);
    op(1, 0, 4'hF, 12'h555, 0, 0);
    op(0, 1, 4'hE, 0, 0, 0);
    op(0, 1, 4'hD, 0, 0, 0);
    // R4 every read offset
    for (int i = 0; i < 16; i++) op(0, 1, 4'(i), 0, 0, 0);
    // random mix
    for (int k = 0; k < 1500; k++) begin
      int kind;
      kind = int'($urandom_range(0, 2));
      op(kind == 1, kind == 2, 4'($urandom()), 12'($urandom()),
         ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
    end
    // R1 reset after activity
    op(1, 0, 4'hD, 12'hFFF, 1, 1);
    do_reset();
    op(0, 1, 4'hE, 0, 0, 0);
    op(0, 1, 4'hD, 0, 0, 0);
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule